// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-ported synchronous burst memory. It has a shared bidirectional data bus that is split into byte lanes. Every control input is sampled on the rising clock edge. Read data passes through an output register, so a read returns its data one clock later than a flow-through memory would. The word depth is a parameter. The lane count and the lane width are also parameters, and their defaults give four 8-bit lanes.

An access starts when a host pulls either of two address strobes low while all three chip-select inputs match. The block latches the address. The two lowest address bits set the start point of a 2-bit wrapping burst. After that, each cycle with the advance input low steps to the next word of the burst. The order is linear or interleaved, and a mode input picks it at load time. A cycle with no strobe and the advance input high suspends the burst:
- A write suspend writes the same word again.
- A read suspend repeats the read.

Writes use either a global write input or a byte-write enable with one select per lane. A sleep input parks the block, but only while it is deselected.

Top module: `burst_sram`

## Requirements
- R1: A read started at rising edge n appears on `dq` between edge n+1 and edge n+2, provided `out_en_n` is low at the time.
- R2: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A strobe with any other select combination ends the burst and starts no access. `dq` stays high impedance from the next edge on.
- R3: An edge with `ads_cpu_n`=0 or `ads_ctl_n`=0 while selected latches `addr`. That word is the first one accessed, and `addr[1:0]` is the burst start offset.
- R4: With no strobe and an active burst, `adv_n`=0 moves the 2-bit burst count forward by one. `adv_n`=1 keeps the same word and repeats the last read.
- R5: With `order_lin`=1 at load, the k-th word of a burst has offset (start + k) mod 4.
- R6: With `order_lin`=0 at load, the k-th word of a burst has offset start XOR k. For example, a start of 1 gives offsets 1, 0, 3, 2.
- R7: `wr_all_n`=0 writes all lanes. `wr_all_n`=1 with `wr_byte_n`=0 and `lane_n`=0000 also writes all lanes.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, only the lanes whose `lane_n` bit is 0 are written. Bit i of `lane_n` controls `dq[8i+7:8i]`, and the other lanes keep their contents.
- R9: A cycle is a read when `wr_all_n`=1 and either `wr_byte_n`=1 or `lane_n`=1111.
- R10: After a write, `dq` stays high impedance until a strobe or an advance starts a read.
- R11: `sleep`=1 puts the block to sleep only when no burst is active. It is ignored during a burst. While asleep, strobes start nothing and `dq` is high impedance. `dq` is still high impedance after waking.
- R12: `out_en_n`=1 sets `dq` to high impedance within the same cycle. It does not disturb the read pipeline, so the data returns when `out_en_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ads_cpu_n | input | 1 | Address strobe, processor side, active low |
| ads_ctl_n | input | 1 | Address strobe, controller side, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | 1 = linear burst, 0 = interleaved burst |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
Writes take effect at the same edge that samples the address. A read driven at edge n is due on the bus after edge n+1, while deselects, write cycles and sleep blank the bus one edge after the cycle that causes them. Only the output enable acts within the cycle. The bench advances its reference model on each rising edge, using the inputs it drove at the previous falling edge. It then compares the bus at the next falling edge, so every expected value already includes the output register and the asynchronous enable.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
   localparam int unsigned OFS_W = 2;
   typedef logic [OFS_W-1:0] ofs_t;

   // offset of the step-th word of a burst
   function automatic ofs_t burst_ofs(input ofs_t start, input ofs_t step, input logic linear);
      return linear ? ofs_t'(start + step) : (start ^ step);
   endfunction
endpackage

// File: rtl/sbs_wdec.sv
module sbs_wdec #(
   parameter int unsigned LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_n,
   output logic [LANES-1:0] we,
   output logic             wr_any
);
   always_comb begin
      if (!wr_all_n)       we = '1;
      else if (!wr_byte_n) we = ~lane_n;
      else                 we = '0;
      wr_any = |we;
   end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sram_burst_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          sel,
   input  logic          ads_cpu_n,
   input  logic          ads_ctl_n,
   input  logic          adv_n,
   input  logic          order_lin,
   input  logic          sleep,
   input  logic          wr_any,
   output logic [AW-1:0] acc_addr,
   output logic          wr_go,
   output logic          rd_pend_q,
   output logic [AW-1:0] rd_addr_q,
   output logic          asleep
);
   localparam int unsigned HI_W = AW - OFS_W;

   logic            strobe, awake, ld, ds, adv, sus, rd_go;
   logic            active_q, sleep_q, last_rd_q, lin_q, lin_n;
   ofs_t            start_q, start_n, cnt_q, cnt_n;
   logic [HI_W-1:0] hi_q, hi_n;

   always_comb begin
      strobe   = !ads_cpu_n || !ads_ctl_n;
      awake    = !sleep_q;
      ld       = awake && strobe && sel;
      ds       = awake && strobe && !sel;
      adv      = awake && !strobe && active_q && !adv_n;
      sus      = awake && !strobe && active_q && adv_n;
      hi_n     = ld ? addr[AW-1:OFS_W] : hi_q;
      start_n  = ld ? addr[OFS_W-1:0] : start_q;
      lin_n    = ld ? order_lin : lin_q;
      cnt_n    = ld ? '0 : (adv ? cnt_q + ofs_t'(1) : cnt_q);
      acc_addr = {hi_n, burst_ofs(start_n, cnt_n, lin_n)};
      wr_go    = (ld || adv || sus) && wr_any;
      rd_go    = !wr_any && (ld || adv || (sus && last_rd_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         sleep_q   <= 1'b0;
         last_rd_q <= 1'b0;
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
         hi_q      <= '0;
         start_q   <= '0;
         cnt_q     <= '0;
         lin_q     <= 1'b1;
      end else begin
         hi_q      <= hi_n;
         start_q   <= start_n;
         cnt_q     <= cnt_n;
         lin_q     <= lin_n;
         if (ld)      active_q <= 1'b1;
         else if (ds) active_q <= 1'b0;
         sleep_q   <= sleep && (sleep_q || (!active_q && !strobe));
         if (rd_go)      last_rd_q <= 1'b1;
         else if (wr_go) last_rd_q <= 1'b0;
         rd_pend_q <= rd_go;
         rd_addr_q <= acc_addr;
      end
   end

   assign asleep = sleep_q;

   AST_DESEL_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) ds |=> (!rd_pend_q && !active_q)); // R2
   AST_LOAD_START:  assert property (@(posedge clk) disable iff (!rst_n) ld |=> (cnt_q == '0) && (start_q == $past(addr[OFS_W-1:0]))); // R3
   AST_ADV_STEP:    assert property (@(posedge clk) disable iff (!rst_n) adv |=> cnt_q == ofs_t'($past(cnt_q) + ofs_t'(1))); // R4
   AST_SUSP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) sus |=> ($stable(cnt_q) && $stable(start_q))); // R4
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !rd_pend_q); // R10
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(sleep_q) |-> !$past(active_q)); // R11
   AST_SLEEP_DEAF:  assert property (@(posedge clk) disable iff (!rst_n) sleep_q |=> !rd_pend_q); // R11
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
   parameter int unsigned AW     = 10,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_go,
   input  logic [LANES-1:0]        we,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_en,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] q,
   output logic                    q_vld
);
   localparam int unsigned DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] q_l;
      always_ff @(posedge clk) begin
         if (wr_go && we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
         if (rd_en)          q_l <= store[raddr];
      end
      assign q[g*LANE_W +: LANE_W] = q_l;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_vld <= 1'b0;
      else        q_vld <= rd_en;
   end

   AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> q_vld); // R1
   AST_NO_STALE:  assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !q_vld); // R10
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import sram_burst_pkg::*;
#(
   parameter int unsigned AW     = 10,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic              ads_cpu_n,
   input  logic              ads_ctl_n,
   input  logic              adv_n,
   input  logic              order_lin,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              out_en_n,
   input  logic              sleep,
   inout  wire [LANES*LANE_W-1:0] dq
);
   localparam int unsigned DW = LANES * LANE_W;

   if (AW <= OFS_W) begin : g_bad_aw
      $error("burst_sram: AW must exceed the burst offset width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: lane count and lane width must be nonzero");
   end

   logic             sel, wr_any, wr_go, rd_pend_q, asleep, q_vld, dq_oe;
   logic [LANES-1:0] we;
   logic [AW-1:0]    acc_addr, rd_addr_q;
   logic [DW-1:0]    q;

   assign sel = !sel1_n && sel2 && !sel3_n;

   sbs_wdec #(.LANES(LANES)) u_wdec (
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
      .we(we), .wr_any(wr_any)
   );

   sbs_ctrl #(.AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel),
      .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
      .order_lin(order_lin), .sleep(sleep), .wr_any(wr_any),
      .acc_addr(acc_addr), .wr_go(wr_go), .rd_pend_q(rd_pend_q),
      .rd_addr_q(rd_addr_q), .asleep(asleep)
   );

   sbs_lane_mem #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .we(we), .waddr(acc_addr),
      .wdata(dq), .rd_en(rd_pend_q), .raddr(rd_addr_q), .q(q), .q_vld(q_vld)
   );

   assign dq_oe = q_vld && !out_en_n && !asleep;
   assign dq    = dq_oe ? q : {DW{1'bz}};
endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
   localparam int CLK_P = 10;
   localparam int AW    = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic          ads_cpu_n = 1'b1, ads_ctl_n = 1'b1, adv_n = 1'b1, order_lin = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1, out_en_n = 1'b1, sleep = 1'b0;
   logic [3:0]    lane_n = 4'hF;
   logic          tb_drive = 1'b0;
   logic [31:0]   tb_wdata = '0;
   wire  [31:0]   dq;

   assign dq = tb_drive ? tb_wdata : 32'bz;

   burst_sram #(.AW(AW), .LANES(4), .LANE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
      .sel3_n(sel3_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
      .adv_n(adv_n), .order_lin(order_lin), .wr_all_n(wr_all_n),
      .wr_byte_n(wr_byte_n), .lane_n(lane_n), .out_en_n(out_en_n),
      .sleep(sleep), .dq(dq)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   string cur_req = "R1";

   // reference model state
   bit          m_act, m_slp, m_lastrd, m_pend, m_qv, m_lin;
   int          m_base, m_k, m_rdaddr;
   logic [31:0] m_q;
   logic [31:0] mem [0:(1<<AW)-1];

   task automatic model_edge();
      bit sel, strobe, ld, ds, adv, sus, rdgo, wrgo, old_act;
      logic [3:0] wm;
      int a;
      if (!rst_n) begin
         m_act = 0; m_slp = 0; m_lastrd = 0; m_pend = 0; m_qv = 0;
         m_lin = 1; m_base = 0; m_k = 0;
         return;
      end
      sel    = !sel1_n && sel2 && !sel3_n;
      strobe = !ads_cpu_n || !ads_ctl_n;
      ld  = !m_slp && strobe && sel;
      ds  = !m_slp && strobe && !sel;
      adv = !m_slp && !strobe && m_act && !adv_n;
      sus = !m_slp && !strobe && m_act && adv_n;
      wm  = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
      if (ld) begin m_base = int'(addr); m_k = 0; m_lin = order_lin; end
      else if (adv) m_k = (m_k + 1) % 4;
      a = m_lin ? ((m_base / 4) * 4 + ((m_base + m_k) % 4))
                : ((m_base / 4) * 4 + ((m_base % 4) ^ m_k));
      // output register takes the pending read before this edge's write
      m_qv = m_pend;
      if (m_pend) m_q = mem[m_rdaddr];
      wrgo = (ld || adv || sus) && (wm != 0);
      rdgo = (wm == 0) && (ld || adv || (sus && m_lastrd));
      if (wrgo)
         for (int i = 0; i < 4; i++)
            if (wm[i]) mem[a][8*i +: 8] = tb_wdata[8*i +: 8];
      m_pend = rdgo; m_rdaddr = a;
      if (rdgo) m_lastrd = 1; else if (wrgo) m_lastrd = 0;
      old_act = m_act;
      if (ld) m_act = 1; else if (ds) m_act = 0;
      m_slp = sleep && (m_slp || (!old_act && !strobe));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      cyc++;
      @(negedge clk);
      if (rst_n && !tb_drive) begin
         checks++;
         if (m_qv && !out_en_n && !m_slp) begin
            if (dq !== m_q) begin
               errors++;
               $display("FAIL %s cycle %0d dq=%h expected=%h", cur_req, cyc, dq, m_q);
            end
         end else if (!(dq === 32'bz || dq === 32'b0)) begin
            errors++;
            $display("FAIL %s cycle %0d dq=%h expected=high-z", cur_req, cyc, dq);
         end
      end
   endtask

   task automatic idle_in();
      ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; tb_drive = 0;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input logic g_n,
                     input logic b_n, input logic [3:0] l_n, input bit lin);
      addr = AW'(a); ads_ctl_n = 0; order_lin = lin;
      wr_all_n = g_n; wr_byte_n = b_n; lane_n = l_n;
      out_en_n = 1; tb_drive = 1; tb_wdata = d;
      step(); idle_in();
   endtask

   task automatic rd(input int a, input bit lin, input bit use_cpu);
      addr = AW'(a); order_lin = lin; out_en_n = 0;
      if (use_cpu) ads_cpu_n = 0; else ads_ctl_n = 0;
      step(); idle_in();
   endtask

   task automatic advance(input int n);
      for (int i = 0; i < n; i++) begin adv_n = 0; step(); end
      adv_n = 1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      cur_req = "R2"; out_en_n = 0; step(); step();  // reset state: bus idle

      cur_req = "R7";  // full writes through global write and all-lane byte write
      for (int i = 0; i < 16; i++)
         wr(i, 32'hA5000001 + i * 32'h01010101, (i % 2) == 0 ? 1'b0 : 1'b1, 1'b0, 4'h0, 1);

      cur_req = "R10"; out_en_n = 0; step(); step(); step();

      cur_req = "R1";  // single reads through both strobes
      for (int i = 0; i < 8; i++) begin rd(i, 1, (i % 2) == 1); step(); end

      cur_req = "R5"; rd(5, 1, 1); advance(3); step(); step();
      cur_req = "R5"; rd(10, 1, 0); advance(5); step();
      cur_req = "R6"; rd(9, 0, 1); advance(3); step();
      cur_req = "R6"; rd(14, 0, 0); advance(3); step();
      cur_req = "R6"; rd(7, 0, 1); advance(3); step();

      cur_req = "R4";  // suspend repeats the current word
      rd(12, 1, 1); advance(1); step(); step(); advance(2); step(); step();

      cur_req = "R8";  // partial writes then read back
      wr(3, 32'h11223344, 1, 0, 4'b1010, 1);
      wr(4, 32'h55667788, 1, 0, 4'b0111, 1);
      wr(6, 32'h99AABBCC, 1, 0, 4'b1100, 1);
      out_en_n = 0; step();
      rd(3, 1, 0); rd(4, 1, 0); rd(6, 1, 0); step(); step();

      cur_req = "R9";  // byte enable with no lane selected reads
      addr = 10'd2; ads_ctl_n = 0; wr_byte_n = 0; lane_n = 4'hF; out_en_n = 0;
      step(); idle_in(); step(); step();

      cur_req = "R10"; // burst write, then suspended cycles with no write
      wr(20, 32'hC0DE0001, 0, 1, 4'hF, 1);
      for (int i = 0; i < 3; i++) begin
         adv_n = 0; wr_all_n = 0; tb_drive = 1; tb_wdata = 32'hC0DE0010 + i;
         out_en_n = 1; step();
      end
      idle_in(); out_en_n = 0; step(); step(); step();
      rd(20, 1, 1); advance(3); step(); step();

      cur_req = "R2";  // deselect by each select input
      rd(1, 1, 1); sel2 = 0; ads_cpu_n = 0; step(); idle_in(); sel2 = 1; step(); advance(2); step();
      sel1_n = 1; addr = 10'd2; ads_ctl_n = 0; step(); idle_in(); sel1_n = 0; step(); step();
      sel3_n = 1; addr = 10'd3; ads_cpu_n = 0; step(); idle_in(); sel3_n = 0; step(); step();

      cur_req = "R12"; // output enable toggles during a burst
      rd(8, 1, 1); out_en_n = 1; adv_n = 0; step(); out_en_n = 0; step();
      out_en_n = 1; step(); step(); adv_n = 1; out_en_n = 0; step(); step();

      cur_req = "R11"; // sleep ignored while active
      rd(0, 1, 1); sleep = 1; advance(3); step(); step();
      sleep = 0; sel1_n = 1; ads_cpu_n = 0; step(); idle_in(); sel1_n = 0;
      sleep = 1; step(); step();
      rd(5, 1, 1); rd(6, 1, 0); step(); step();
      sleep = 0; step(); step();
      rd(5, 1, 1); step(); step();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule